// File: doc/BRIEF.md
# UART Receive Queue with Status and Interrupt Word

This block sits behind the serial receiver of a UART. Every character that arrives is pushed into a 16-entry queue. Four error tags travel with the character: break, framing error, parity error and overrun. Software reads characters through a small register bus. The status word always describes the character that software will read next, not the most recent arrival.

Three sticky event bits sit next to the per-entry tags:
- The receive-error event bit sets in the cycle a faulty character is stored.
- The timeout event bit records a receive-timeout pulse.
- The transmit-space event bit records that the transmit queue has room of at least a programmed level.

Each event bit is cleared by writing zero to it. The enabled event bits are combined into one interrupt line.

Top module: `uart_rx_status`

## Requirements
- R1: Characters are read in arrival order. A read at address 0 returns the head character in `reg_rdata[7:0]` on the cycle after the read strobe, with the upper bits 0, and removes that character. A read at address 0 when the queue is empty returns 0 and removes nothing. The queue holds 16 characters.
- R2: Status bits 15 (break), 13 (framing), 12 (parity) and 11 (overrun) show the tags of the head character. They change to the tags of the next character in the cycle after the head is removed.
- R3: Status bit 14 is 1 while the queue is empty and 0 while it holds at least one character.
- R4: A character that arrives while the queue is full, with no removal in the same cycle, is discarded. The overrun tag of the newest stored character is then set. A full queue that is read in the same cycle as an arrival accepts the new character.
- R5: Status bit 10 (receive-error event) becomes 1 in the cycle after a character arrives with a framing, parity or overrun flag, or is discarded under R4. This does not wait for the character to reach the head.
- R6: Status bit 9 (timeout event) becomes 1 in the cycle after a `rx_timeout` pulse.
- R7: Status bit 8 (transmit-space event) becomes 1 in the cycle after any cycle in which `tx_free` is at least the level held in control bits [4:0].
- R8: A write to address 1 clears each of status bits 10, 9 and 8 whose data bit is 0, and leaves each bit whose data bit is 1 unchanged. A hardware set in the same cycle wins over the clear.
- R9: Writes to address 1 leave status bits 15 to 11 and 14 unchanged.
- R10: Control bits [18:16] at address 2 enable the events in the order receive-error, timeout, transmit-space. `irq` is 1 in the cycle after a cycle in which any enabled event bit is 1.
- R11: After reset the status word is 0x0000_4100. The control register holds level 8 with all enables 0, `irq` is 0 and `reg_rdata` is 0. Head tags read 0 while the queue is empty.
- R12: A read at address 1 returns the status word. A read at address 2 returns the control register. Status bits other than 15 to 8 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_data | input | 8 | Received character |
| rx_brk | input | 1 | Break flag for this character |
| rx_ferr | input | 1 | Framing error flag for this character |
| rx_perr | input | 1 | Parity error flag for this character |
| rx_oerr | input | 1 | Overrun flag reported by the receiver |
| rx_timeout | input | 1 | Receive-timeout pulse |
| tx_free | input | 5 | Free entries in the transmit queue |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 data, 1 status, 2 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| status | output | 32 | Live status word |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest state to reach from the ports is a full queue at the moment another character arrives. Two variants matter. In the first, the character is discarded and the overrun tag is set on the newest entry. In the second, a read in the same cycle lets the character in. The stimulus fills the queue with 16 clean characters and sends two more. It then drives an arrival and an address-0 read in the same cycle. Finally it drains the queue, so the late overrun tag is seen at the head only after 15 reads. A second corner is the race between a hardware set and a software write-zero. The bench creates it by pulsing `rx_timeout` and by holding `tx_free` above the level while the clearing write is on the bus.

// File: rtl/uart_rxs_pkg.sv
package uart_rxs_pkg;
  localparam int BUS_W = 32;

  // register addresses
  localparam logic [1:0] A_RXD  = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;

  // status word bit positions
  localparam int S_BRK   = 15;
  localparam int S_EMPTY = 14;
  localparam int S_FERR  = 13;
  localparam int S_PERR  = 12;
  localparam int S_OERR  = 11;
  localparam int S_ERRI  = 10;
  localparam int S_TOUT  = 9;
  localparam int S_TXS   = 8;

  // control word: enables start here
  localparam int C_EN_LSB = 16;

  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
    logic oerr;
  } rx_tag_t;
endpackage

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
  import uart_rxs_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          mark_ovr,
  input  logic [DW-1:0] din,
  input  rx_tag_t       tag_in,
  output logic [DW-1:0] head_data,
  output rx_tag_t       head_tag,
  output logic          empty,
  output logic          full
);
  logic [DW-1:0] ram [DEPTH];
  rx_tag_t       tags [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, last_ptr;
  logic [AW:0]   cnt;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign last_ptr = (wr_ptr == '0) ? AW'(DEPTH - 1) : wr_ptr - 1'b1;
  assign empty    = (cnt == '0);
  assign full     = (cnt == (AW+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= inc(wr_ptr);
      if (pop)  rd_ptr <= inc(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // character storage: no reset, single write port
  always_ff @(posedge clk) begin
    if (push) ram[wr_ptr] <= din;
  end

  // tags stay in flops: the overrun tag is modified after the write
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) tags[i] <= '0;
    end else begin
      if (push)     tags[wr_ptr]        <= tag_in;
      if (mark_ovr) tags[last_ptr].oerr <= 1'b1;
    end
  end

  assign head_data = empty ? '0 : ram[rd_ptr];
  assign head_tag  = empty ? '0 : tags[rd_ptr];

  assert_depth_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= (AW+1)'(DEPTH));
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (full && !pop) |-> !push);
  assert_empty_no_pop_R1: assert property (@(posedge clk) disable iff (rst)
    empty |-> !pop);
endmodule

// File: rtl/sticky_bits.sv
module sticky_bits #(
  parameter int         N   = 3,
  parameter logic [N-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                  q[i] <= RST[i];
      else if (set[i])          q[i] <= 1'b1;
      else if (wr && !wdata[i]) q[i] <= 1'b0;
    end

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> q[i]);
    assert_zero_clears_R8: assert property (@(posedge clk) disable iff (rst)
      (wr && !wdata[i] && !set[i]) |=> !q[i]);
    assert_one_keeps_R8: assert property (@(posedge clk) disable iff (rst)
      (!(wr && !wdata[i]) && !set[i]) |=> $stable(q[i]));
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rxs_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int DW         = 8,
  parameter int TXW        = 5,
  parameter int TX_LVL_RST = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_data,
  input  logic             rx_brk,
  input  logic             rx_ferr,
  input  logic             rx_perr,
  input  logic             rx_oerr,
  input  logic             rx_timeout,
  input  logic [TXW-1:0]   tx_free,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  output logic [BUS_W-1:0] status,
  output logic             irq
);
  localparam int NEV = 3; // [2] receive error, [1] timeout, [0] tx space

  logic [DW-1:0]  head_data;
  rx_tag_t        head_tag, tag_in;
  logic           empty, full, pop, push, ovf;
  logic [NEV-1:0] ev_set, ev_q, ev_en;
  logic [TXW-1:0] tx_lvl;
  logic [BUS_W-1:0] ctrl_word;
  logic           stat_wr;

  assign pop     = reg_rd && (reg_addr == A_RXD) && !empty;
  assign push    = rx_valid && (!full || pop);
  assign ovf     = rx_valid && full && !pop;
  assign tag_in  = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, oerr: rx_oerr};
  assign stat_wr = reg_wr && (reg_addr == A_STAT);

  assign ev_set[2] = (rx_valid && (rx_ferr || rx_perr || rx_oerr)) || ovf;
  assign ev_set[1] = rx_timeout;
  assign ev_set[0] = (tx_free >= tx_lvl);

  rx_tag_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .mark_ovr(ovf),
    .din(rx_data), .tag_in(tag_in), .head_data(head_data),
    .head_tag(head_tag), .empty(empty), .full(full)
  );

  sticky_bits #(.N(NEV), .RST(3'b001)) u_ev (
    .clk(clk), .rst(rst), .set(ev_set), .wr(stat_wr),
    .wdata(reg_wdata[S_ERRI:S_TXS]), .q(ev_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_lvl <= TXW'(TX_LVL_RST);
      ev_en  <= '0;
    end else if (reg_wr && (reg_addr == A_CTRL)) begin
      tx_lvl <= reg_wdata[TXW-1:0];
      ev_en  <= reg_wdata[C_EN_LSB +: NEV];
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[TXW-1:0] = tx_lvl;
    ctrl_word[C_EN_LSB +: NEV] = ev_en;
  end

  always_comb begin
    status = '0;
    status[S_BRK]   = head_tag.brk;
    status[S_EMPTY] = empty;
    status[S_FERR]  = head_tag.ferr;
    status[S_PERR]  = head_tag.perr;
    status[S_OERR]  = head_tag.oerr;
    status[S_ERRI:S_TXS] = ev_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= |(ev_q & ev_en);
      if (reg_rd) begin
        case (reg_addr)
          A_RXD:   reg_rdata <= BUS_W'(head_data);
          A_STAT:  reg_rdata <= status;
          A_CTRL:  reg_rdata <= ctrl_word;
          default: reg_rdata <= '0;
        endcase
      end
    end
  end

  assert_avail_on_push_R3: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !pop) |=> !status[S_EMPTY]);
  assert_head_zero_empty_R11: assert property (@(posedge clk) disable iff (rst)
    status[S_EMPTY] |-> (status[15:11] == 5'b01000));
  assert_tags_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!pop && !rx_valid) |=> $stable(status[15:11]));
  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (rst)
    (|(status[S_ERRI:S_TXS] & ev_en)) |=> irq);
  assert_err_immediate_R5: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_ferr) |=> status[S_ERRI]);
endmodule

// File: tb/sim_uart_rx_status.sv
`timescale 1ns/1ps
module sim_uart_rx_status;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 0, rx_brk = 0, rx_ferr = 0, rx_perr = 0, rx_oerr = 0;
  logic [7:0]  rx_data = '0;
  logic        rx_timeout = 0;
  logic [4:0]  tx_free = '0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, status;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_rx_status u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_brk(rx_brk), .rx_ferr(rx_ferr), .rx_perr(rx_perr), .rx_oerr(rx_oerr),
    .rx_timeout(rx_timeout), .tx_free(tx_free), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .status(status), .irq(irq)
  );

  // reference model; entry = {brk, ferr, perr, oerr, data}
  logic [11:0] q[$];
  bit        m_erri, m_tout, m_txs, m_irq;
  bit [4:0]  m_lvl;
  bit [2:0]  m_en;
  bit [31:0] m_rdata;

  function automatic bit [31:0] m_stat();
    bit [31:0] s = '0;
    bit [11:0] h = (q.size() > 0) ? q[0] : 12'h0;
    s[15] = h[11]; s[14] = (q.size() == 0); s[13] = h[10];
    s[12] = h[9];  s[11] = h[8];
    s[10] = m_erri; s[9] = m_tout; s[8] = m_txs;
    return s;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit [31:0] old_stat = m_stat();
    bit [31:0] ctl = '0;
    bit pop, push, ovf, s_err, s_to, s_tx;
    if (rst) begin
      q.delete(); m_erri = 0; m_tout = 0; m_txs = 1; m_irq = 0;
      m_lvl = 5'd8; m_en = 3'b000; m_rdata = '0;
      return;
    end
    ctl[4:0] = m_lvl; ctl[18:16] = m_en;
    pop  = reg_rd && reg_addr == 2'd0 && q.size() > 0;
    push = rx_valid && (q.size() < 16 || pop);
    ovf  = rx_valid && q.size() == 16 && !pop;
    m_irq = |({m_erri, m_tout, m_txs} & m_en);
    if (reg_rd) begin
      case (reg_addr)
        2'd0: m_rdata = pop ? {24'h0, q[0][7:0]} : 32'h0;
        2'd1: m_rdata = old_stat;
        2'd2: m_rdata = ctl;
        default: m_rdata = 32'h0;
      endcase
    end
    s_err = (rx_valid && (rx_ferr || rx_perr || rx_oerr)) || ovf;
    s_to  = rx_timeout;
    s_tx  = (tx_free >= m_lvl);
    if (reg_wr && reg_addr == 2'd1) begin
      if (!reg_wdata[10]) m_erri = 0;
      if (!reg_wdata[9])  m_tout = 0;
      if (!reg_wdata[8])  m_txs  = 0;
    end
    if (s_err) m_erri = 1;
    if (s_to)  m_tout = 1;
    if (s_tx)  m_txs  = 1;
    if (reg_wr && reg_addr == 2'd2) begin
      m_lvl = reg_wdata[4:0];
      m_en  = reg_wdata[18:16];
    end
    if (pop) void'(q.pop_front());
    if (ovf) q[q.size()-1][8] = 1'b1;
    if (push) q.push_back({rx_brk, rx_ferr, rx_perr, rx_oerr, rx_data});
  endtask

  task automatic compare();
    bit [31:0] s = m_stat();
    chk("R2", "head break",   status[15], s[15]);
    chk("R3", "empty flag",   status[14], s[14]);
    chk("R2", "head framing", status[13], s[13]);
    chk("R2", "head parity",  status[12], s[12]);
    chk("R4", "head overrun", status[11], s[11]);
    chk("R5", "error event",  status[10], s[10]);
    chk("R6", "timeout event", status[9], s[9]);
    chk("R7", "tx event",     status[8],  s[8]);
    chk("R12", "unused status bits", {status[31:16], status[7:0]}, 24'h0);
    chk("R10", "irq", irq, m_irq);
    chk("R1", "read data", reg_rdata, m_rdata);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    rx_valid = 0; rx_brk = 0; rx_ferr = 0; rx_perr = 0; rx_oerr = 0;
    rx_timeout = 0; reg_wr = 0; reg_rd = 0;
  endtask

  task automatic push_ch(bit [7:0] d, bit b, bit f, bit p, bit o);
    rx_valid = 1; rx_data = d; rx_brk = b; rx_ferr = f; rx_perr = p; rx_oerr = o;
    cyc();
  endtask

  task automatic rd(bit [1:0] a);
    reg_rd = 1; reg_addr = a;
    cyc();
  endtask

  task automatic wr(bit [1:0] a, bit [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cyc();
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) cyc();
    rst = 0;
    // R11: reset state
    chk("R11", "reset status", status, 32'h0000_4100);
    chk("R11", "reset irq", irq, 1'b0);
    rd(2'd2);
    chk("R11", "reset control", reg_rdata, 32'h0000_0008);

    // R10: enable all events, level 4; tx event from reset raises irq
    wr(2'd2, 32'h0007_0004);
    cyc(); cyc();
    chk("R10", "irq from tx event", irq, 1'b1);
    wr(2'd1, 32'h0);          // R8: clear all three
    cyc();

    // R2/R5: tagged characters, head reporting
    push_ch(8'h11, 0, 0, 0, 0);
    push_ch(8'h22, 0, 1, 0, 0);
    push_ch(8'h33, 1, 0, 1, 0);
    rd(2'd1);                 // R12 status read
    rd(2'd0); rd(2'd0); rd(2'd0);
    rd(2'd0);                 // R1 empty read returns 0
    wr(2'd1, 32'h0);

    // R4: fill, overflow, then arrival with simultaneous read
    for (int i = 0; i < 16; i++) push_ch(8'h40 + 8'(i), 0, 0, 0, 0);
    push_ch(8'hEE, 0, 0, 0, 0);
    push_ch(8'hEF, 1, 0, 0, 0);
    rx_valid = 1; rx_data = 8'h5A; reg_rd = 1; reg_addr = 2'd0;
    cyc();
    for (int i = 0; i < 17; i++) rd(2'd0);
    wr(2'd1, 32'h0);

    // R6/R8: timeout set against a clear in the same cycle
    rx_timeout = 1; reg_wr = 1; reg_addr = 2'd1; reg_wdata = 32'h0;
    cyc();
    wr(2'd1, 32'hFFFF_FFFF);  // write ones: no change
    wr(2'd1, 32'h0);

    // R7: tx space compare around level 4
    tx_free = 5'd3; cyc();
    tx_free = 5'd4; cyc();
    wr(2'd1, 32'h0);          // set wins while still at level
    tx_free = 5'd2; cyc();
    wr(2'd1, 32'h0);
    tx_free = 5'd31; cyc();
    tx_free = 5'd0; wr(2'd1, 32'h0);

    // R9: writes do not touch head tags or the empty flag
    push_ch(8'h77, 1, 1, 1, 1);
    wr(2'd1, 32'h0000_0000);
    wr(2'd1, 32'h0000_FFFF);
    chk("R9", "head tags after writes", status[15:11], 5'b10111);
    rd(2'd0);
    wr(2'd1, 32'h0);

    // R10: enables gate the interrupt
    wr(2'd2, 32'h0000_0004);
    rx_timeout = 1; cyc();
    cyc();
    chk("R10", "irq masked", irq, 1'b0);
    wr(2'd2, 32'h0002_0004);
    cyc();
    chk("R10", "irq timeout enabled", irq, 1'b1);
    rd(2'd2);
    wr(2'd1, 32'h0);
    cyc(); cyc();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule